// File: doc/BRIEF.md
# DMA Request Routing Multiplexer

This block sits between a field of peripheral request lines and the per-channel request inputs of a DMA engine. Each output channel owns a 32-bit configuration word that picks one of up to 128 source slots and one of five behaviours. In the off behaviour the channel is silent. In pass-through the chosen source request goes straight to the channel. In triggered pass-through a periodic trigger edge arms a one-shot latch, and the next source request is forwarded once. In steady request the channel is held asserted with no peripheral involved. In triggered request the channel pulses once on every trigger edge.

Only the lowest `NUM_TRIG` channels have a periodic trigger input. On every other channel the trigger control bit is not stored and has no effect. Once a channel is enabled, its source slot and trigger bit are locked. A write then changes only the enable and steady-request bits, so a live channel cannot be silently rerouted. If several enabled channels name the same source slot, only the lowest-numbered one forwards that source's request.

Top module: `dmarq_router`

## Requirements
- R1: After reset every configuration word reads 0 and every channel request output is 0.
- R2: Configuration word fields: bit 31 enable, bit 30 trigger enable, bit 29 steady request, bits 6:0 source slot. All other bits are ignored on write and read back as 0.
- R3: A channel whose enable bit is 0 never asserts its request output.
- R4: Enable=1, trigger=0, steady=0: the request output equals the selected source request in the same cycle.
- R5: Enable=1, trigger=1, steady=0: a rising edge on the channel's trigger input arms a latch from the next cycle. While the latch is armed, the output follows the selected source request. The latch clears in the cycle after it forwards a request. A trigger held high arms only once.
- R6: Enable=1, steady=1, trigger=0: the request output is 1 whatever the source inputs do.
- R7: Enable=1, steady=1, trigger=1: the request output is 1 in exactly the cycle in which the trigger input rises, and 0 otherwise.
- R8: On channels at or above NUM_TRIG, the trigger bit is not stored. It reads back 0, and the channel behaves as if it were clear.
- R9: A write to an enabled channel leaves its source slot and trigger bit unchanged and updates only enable and steady request.
- R10: When enabled channels share a source slot, only the lowest-numbered of them forwards that source's request. The others output 0 for it.
- R11: An armed trigger latch is discarded when its channel leaves triggered pass-through, so re-enabling does not forward a stale trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_W | Channel addressed by the write |
| cfg_wdata | input | 32 | Configuration word to write |
| rd_ch | input | CH_W | Channel whose configuration is read |
| rd_data | output | 32 | Configuration word of channel rd_ch |
| src_req | input | NUM_SRC | Peripheral source request lines |
| trig_in | input | NUM_TRIG | Periodic trigger inputs, one per low channel |
| ch_req | output | NUM_CH | Request lines toward the DMA engine |

## Verification
Pass-through is driven with the selected source toggling alone and alongside an unselected source. This shows that routing follows the stored slot and not the last written one. Triggered pass-through is exercised with four patterns:
- a one-cycle trigger while the source is high;
- a trigger held high for several cycles, which separates edge detection from level sensing;
- a trigger that comes before the source rises, which shows the latch waits;
- a trigger followed by disable and re-enable, which shows a stale arm is dropped.

Steady and triggered-request channels are run with all sources low to show they need no peripheral. A shared slot is driven on two channels, before and after the lower one is disabled.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;

    localparam int CFG_W    = 32;
    localparam int SLOT_W   = 7;
    localparam int EN_BIT   = 31;
    localparam int TRIG_BIT = 30;
    localparam int HOLD_BIT = 29;

    typedef struct packed {
        logic              en;
        logic              trig;
        logic              hold;
        logic [SLOT_W-1:0] slot;
    } chan_cfg_t;

    typedef enum logic [2:0] {
        MODE_OFF,
        MODE_PASS,
        MODE_PERIODIC,
        MODE_STEADY,
        MODE_PULSE
    } route_mode_e;

    function automatic route_mode_e decode_mode(logic en, logic trig, logic hold);
        route_mode_e m;
        if (!en)                m = MODE_OFF;
        else if (hold && trig)  m = MODE_PULSE;
        else if (hold)          m = MODE_STEADY;
        else if (trig)          m = MODE_PERIODIC;
        else                    m = MODE_PASS;
        return m;
    endfunction

    function automatic logic [CFG_W-1:0] pack_cfg(chan_cfg_t c);
        logic [CFG_W-1:0] w;
        w               = '0;
        w[EN_BIT]       = c.en;
        w[TRIG_BIT]     = c.trig;
        w[HOLD_BIT]     = c.hold;
        w[SLOT_W-1:0]   = c.slot;
        return w;
    endfunction

endpackage

// File: rtl/dmarq_cfg_bank.sv
module dmarq_cfg_bank
    import dmarq_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int NUM_TRIG = 4,
    parameter int CH_W     = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [CH_W-1:0]         wr_ch,
    input  logic [CFG_W-1:0]        wdata,
    input  logic [CH_W-1:0]         rd_ch,
    output logic [CFG_W-1:0]        rd_data,
    output chan_cfg_t [NUM_CH-1:0]  cfg_vec
);

    chan_cfg_t wr_cfg;
    logic      wdata_unused;

    assign wr_cfg.en   = wdata[EN_BIT];
    assign wr_cfg.trig = wdata[TRIG_BIT];
    assign wr_cfg.hold = wdata[HOLD_BIT];
    assign wr_cfg.slot = wdata[SLOT_W-1:0];
    assign wdata_unused = ^wdata[HOLD_BIT-1:SLOT_W];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        assign hit = we && (wr_ch == CH_W'(c));

        // Control bits that may always change.
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_vec[c].en   <= 1'b0;
                cfg_vec[c].hold <= 1'b0;
            end else if (hit) begin
                cfg_vec[c].en   <= wr_cfg.en;
                cfg_vec[c].hold <= wr_cfg.hold;
            end
        end

        // Routing fields locked while the channel is enabled.
        always_ff @(posedge clk) begin
            if (rst)
                cfg_vec[c].slot <= '0;
            else if (hit && !cfg_vec[c].en)
                cfg_vec[c].slot <= wr_cfg.slot;
        end

        if (c < NUM_TRIG) begin : g_trig
            always_ff @(posedge clk) begin
                if (rst)
                    cfg_vec[c].trig <= 1'b0;
                else if (hit && !cfg_vec[c].en)
                    cfg_vec[c].trig <= wr_cfg.trig;
            end
        end else begin : g_notrig
            assign cfg_vec[c].trig = 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_ch) < NUM_CH)
            rd_data = pack_cfg(cfg_vec[rd_ch]);
    end

endmodule

// File: rtl/dmarq_claim.sv
module dmarq_claim
    import dmarq_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  chan_cfg_t [NUM_CH-1:0] cfg_vec,
    output logic      [NUM_CH-1:0] own
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_own
        always_comb begin
            own[c] = 1'b1;
            for (int j = 0; j < c; j++) begin
                if (cfg_vec[j].en && (cfg_vec[j].slot == cfg_vec[c].slot))
                    own[c] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/dmarq_gate.sv
module dmarq_gate
    import dmarq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic trig,
    input  logic hold,
    input  logic sel_req,
    input  logic owner,
    input  logic trig_evt,
    output logic req
);

    route_mode_e mode;
    logic        arm_q;
    logic        fwd;

    assign mode = decode_mode(en, trig, hold);
    assign fwd  = arm_q & sel_req & owner;

    always_ff @(posedge clk) begin
        if (rst)
            arm_q <= 1'b0;
        else if (mode != MODE_PERIODIC)
            arm_q <= 1'b0;
        else
            arm_q <= trig_evt | (arm_q & ~fwd);
    end

    always_comb begin
        unique case (mode)
            MODE_PASS:     req = sel_req & owner;
            MODE_PERIODIC: req = fwd;
            MODE_STEADY:   req = 1'b1;
            MODE_PULSE:    req = trig_evt;
            default:       req = 1'b0;
        endcase
    end

endmodule

// File: rtl/dmarq_router.sv
module dmarq_router
    import dmarq_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int NUM_SRC  = 128,
    parameter int NUM_TRIG = 4,
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [CH_W-1:0]     cfg_ch,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic [CH_W-1:0]     rd_ch,
    output logic [CFG_W-1:0]    rd_data,
    input  logic [NUM_SRC-1:0]  src_req,
    input  logic [NUM_TRIG-1:0] trig_in,
    output logic [NUM_CH-1:0]   ch_req
);

    chan_cfg_t [NUM_CH-1:0]             cfg_vec;
    logic      [NUM_CH-1:0]             own_vec;
    logic      [NUM_CH-1:0]             sel_req;
    logic      [NUM_CH-1:0]             ch_evt;
    logic      [NUM_CH-1:0]             en_vec;
    logic      [NUM_CH-1:0]             hold_vec;
    logic      [NUM_CH-1:0]             trg_vec;
    logic      [NUM_CH-1:0][SLOT_W-1:0] slot_vec;
    logic      [NUM_TRIG-1:0]           trig_prev;
    logic      [NUM_TRIG-1:0]           trig_evt;

    dmarq_cfg_bank #(
        .NUM_CH   (NUM_CH),
        .NUM_TRIG (NUM_TRIG),
        .CH_W     (CH_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .wr_ch   (cfg_ch),
        .wdata   (cfg_wdata),
        .rd_ch   (rd_ch),
        .rd_data (rd_data),
        .cfg_vec (cfg_vec)
    );

    dmarq_claim #(
        .NUM_CH (NUM_CH)
    ) u_claim (
        .cfg_vec (cfg_vec),
        .own     (own_vec)
    );

    always_ff @(posedge clk) begin
        if (rst)
            trig_prev <= '0;
        else
            trig_prev <= trig_in;
    end

    assign trig_evt = trig_in & ~trig_prev;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        assign en_vec[c]   = cfg_vec[c].en;
        assign hold_vec[c] = cfg_vec[c].hold;
        assign trg_vec[c]  = cfg_vec[c].trig;
        assign slot_vec[c] = cfg_vec[c].slot;
        assign sel_req[c]  = (int'(cfg_vec[c].slot) < NUM_SRC) ? src_req[cfg_vec[c].slot] : 1'b0;

        if (c < NUM_TRIG) begin : g_evt
            assign ch_evt[c] = trig_evt[c];
        end else begin : g_noevt
            assign ch_evt[c] = 1'b0;
        end

        dmarq_gate u_gate (
            .clk      (clk),
            .rst      (rst),
            .en       (cfg_vec[c].en),
            .trig     (cfg_vec[c].trig),
            .hold     (cfg_vec[c].hold),
            .sel_req  (sel_req[c]),
            .owner    (own_vec[c]),
            .trig_evt (ch_evt[c]),
            .req      (ch_req[c])
        );
    end

endmodule

// File: rtl/dmarq_router_chk.sv
module dmarq_router_chk #(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3,
    parameter int SLOT_W = 7
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            cfg_we,
    input logic [CH_W-1:0]                 cfg_ch,
    input logic [NUM_CH-1:0]               en_vec,
    input logic [NUM_CH-1:0]               hold_vec,
    input logic [NUM_CH-1:0]               trg_vec,
    input logic [NUM_CH-1:0][SLOT_W-1:0]   slot_vec,
    input logic [NUM_CH-1:0]               sel_req,
    input logic [NUM_CH-1:0]               ch_req
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en_vec == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_c
        // R3
        off_silent_chk: assert property (@(posedge clk) disable iff (rst)
            !en_vec[c] |-> !ch_req[c]);

        // R6
        steady_high_chk: assert property (@(posedge clk) disable iff (rst)
            (en_vec[c] && hold_vec[c] && !trg_vec[c]) |-> ch_req[c]);

        // R4
        source_backed_chk: assert property (@(posedge clk) disable iff (rst)
            (ch_req[c] && !hold_vec[c]) |-> sel_req[c]);

        // R9
        route_lock_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && (cfg_ch == CH_W'(c)) && en_vec[c])
                |=> ($stable(slot_vec[c]) && $stable(trg_vec[c])));

        for (genvar j = 0; j < c; j++) begin : g_j
            // R10
            lower_wins_chk: assert property (@(posedge clk) disable iff (rst)
                (en_vec[j] && en_vec[c] && !hold_vec[c] && (slot_vec[j] == slot_vec[c]))
                    |-> !ch_req[c]);
        end
    end

endmodule

bind dmarq_router dmarq_router_chk #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W),
    .SLOT_W (dmarq_pkg::SLOT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_ch   (cfg_ch),
    .en_vec   (en_vec),
    .hold_vec (hold_vec),
    .trg_vec  (trg_vec),
    .slot_vec (slot_vec),
    .sel_req  (sel_req),
    .ch_req   (ch_req)
);

// File: tb/dmarq_router_tb_top.sv
`timescale 1ns/1ps
module dmarq_router_tb_top;

    localparam int NUM_CH   = 8;
    localparam int NUM_SRC  = 128;
    localparam int NUM_TRIG = 4;
    localparam int CH_W     = 3;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                cfg_we = 1'b0;
    logic [CH_W-1:0]     cfg_ch = '0;
    logic [31:0]         cfg_wdata = '0;
    logic [CH_W-1:0]     rd_ch = '0;
    logic [31:0]         rd_data;
    logic [NUM_SRC-1:0]  src_req = '0;
    logic [NUM_TRIG-1:0] trig_in = '0;
    logic [NUM_CH-1:0]   ch_req;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    typedef struct {
        bit          is_rd;
        int          idx;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #2.5 clk = ~clk;

    dmarq_router #(
        .NUM_CH   (NUM_CH),
        .NUM_SRC  (NUM_SRC),
        .NUM_TRIG (NUM_TRIG)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_ch    (cfg_ch),
        .cfg_wdata (cfg_wdata),
        .rd_ch     (rd_ch),
        .rd_data   (rd_data),
        .src_req   (src_req),
        .trig_in   (trig_in),
        .ch_req    (ch_req)
    );

    // Monitor: compares queued expectations shortly after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                sb_item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_rd ? rd_data : {31'd0, ch_req[it.idx]};
                n_tests++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: %s ch%0d actual=%h expected=%h",
                             it.tag, it.is_rd ? "rd_data" : "ch_req", it.idx, act, it.exp);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic expect_req(int c, bit v, string tag);
        sb_item_t it;
        it.is_rd = 1'b0; it.idx = c; it.exp = {31'd0, v}; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic expect_rd(int c, logic [31:0] v, string tag);
        sb_item_t it;
        rd_ch = CH_W'(c);
        it.is_rd = 1'b1; it.idx = c; it.exp = v; it.tag = tag;
        sb_q.push_back(it);
        tick();
    endtask

    task automatic wr(int c, logic [31:0] d);
        cfg_we    = 1'b1;
        cfg_ch    = CH_W'(c);
        cfg_wdata = d;
        tick();
        cfg_we    = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        done = 1'b1;
        $finish;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int c = 0; c < NUM_CH; c++) expect_req(c, 1'b0, "R1");
        expect_rd(0, 32'h0, "R1");
        expect_rd(5, 32'h0, "R1");

        // R2 field layout, junk bits dropped; R4 pass-through
        wr(1, 32'h8000_1F45);
        expect_rd(1, 32'h8000_0045, "R2");
        src_req[69] = 1'b1;
        expect_req(1, 1'b1, "R4"); tick();
        src_req[69] = 1'b0;
        expect_req(1, 1'b0, "R4"); tick();

        // R9 reroute attempt while enabled
        wr(1, 32'hC000_0010);
        expect_rd(1, 32'h8000_0045, "R9");
        src_req[16] = 1'b1;
        expect_req(1, 1'b0, "R9"); tick();
        src_req[69] = 1'b1;
        expect_req(1, 1'b1, "R9"); tick();
        src_req[16] = 1'b0; src_req[69] = 1'b0;
        wr(1, 32'h0000_0000);
        expect_rd(1, 32'h0000_0045, "R9");
        src_req[69] = 1'b1;
        expect_req(1, 1'b0, "R3"); tick();
        src_req[69] = 1'b0;
        wr(1, 32'h0000_0010);
        expect_rd(1, 32'h0000_0010, "R9");

        // R5 triggered pass-through on channel 2
        wr(2, 32'h4000_0007);
        wr(2, 32'hC000_0007);
        expect_rd(2, 32'hC000_0007, "R2");
        src_req[7] = 1'b1;
        expect_req(2, 1'b0, "R5"); tick();
        trig_in[2] = 1'b1;
        expect_req(2, 1'b0, "R5"); tick();
        trig_in[2] = 1'b0;
        expect_req(2, 1'b1, "R5"); tick();
        expect_req(2, 1'b0, "R5"); tick();
        // held trigger arms once
        trig_in[2] = 1'b1;
        expect_req(2, 1'b0, "R5"); tick();
        expect_req(2, 1'b1, "R5"); tick();
        expect_req(2, 1'b0, "R5"); tick();
        trig_in[2] = 1'b0;
        expect_req(2, 1'b0, "R5"); tick();
        // trigger before source: latch waits
        src_req[7] = 1'b0;
        trig_in[2] = 1'b1;
        expect_req(2, 1'b0, "R5"); tick();
        trig_in[2] = 1'b0;
        expect_req(2, 1'b0, "R5"); tick();
        expect_req(2, 1'b0, "R5"); tick();
        src_req[7] = 1'b1;
        expect_req(2, 1'b1, "R5"); tick();
        expect_req(2, 1'b0, "R5"); tick();

        // R11 stale arm dropped across disable
        src_req[7] = 1'b0;
        trig_in[2] = 1'b1; tick();
        trig_in[2] = 1'b0;
        wr(2, 32'h4000_0007);
        wr(2, 32'hC000_0007);
        src_req[7] = 1'b1;
        expect_req(2, 1'b0, "R11"); tick();
        src_req[7] = 1'b0;
        wr(2, 32'h0000_0000);

        // R6 steady request on channel 3
        wr(3, 32'hA000_0000);
        expect_req(3, 1'b1, "R6"); tick();
        expect_req(3, 1'b1, "R6"); tick();

        // R7 triggered request on channel 0
        wr(0, 32'h6000_0000);
        wr(0, 32'hE000_0000);
        expect_req(0, 1'b0, "R7"); tick();
        trig_in[0] = 1'b1;
        expect_req(0, 1'b1, "R7"); tick();
        expect_req(0, 1'b0, "R7"); tick();
        trig_in[0] = 1'b0; tick();
        trig_in[0] = 1'b1;
        expect_req(0, 1'b1, "R7"); tick();
        trig_in[0] = 1'b0;
        expect_req(0, 1'b0, "R7"); tick();

        // R8 trigger bit ignored above NUM_TRIG
        wr(5, 32'h4000_0009);
        expect_rd(5, 32'h0000_0009, "R8");
        wr(5, 32'hC000_0009);
        expect_rd(5, 32'h8000_0009, "R8");
        src_req[9] = 1'b1;
        expect_req(5, 1'b1, "R8"); tick();
        src_req[9] = 1'b0;
        wr(6, 32'hE000_0000);
        expect_req(6, 1'b1, "R8"); tick();
        expect_req(6, 1'b1, "R8"); tick();

        // R10 shared slot: lowest channel wins
        wr(4, 32'h8000_0020);
        wr(7, 32'h8000_0020);
        src_req[32] = 1'b1;
        expect_req(4, 1'b1, "R10");
        expect_req(7, 1'b0, "R10"); tick();
        wr(4, 32'h0000_0000);
        expect_req(7, 1'b1, "R10");
        expect_req(4, 1'b0, "R3"); tick();

        tick();
        tick();
        finish_run();
    end

endmodule